// File: doc/BRIEF.md
# Bus Slave Transfer Timing Controller

This block is the control side of a memory-backed slave on a synchronous on-chip bus with separate address and data phases. A master presents an address phase: a valid strobe, a read/write select, a burst flag, byte-enable lines and a word address. The slave answers with an address acknowledge and then runs the data phase. During that phase it paces read and write data acknowledges at one beat per clock, raises a transfer-complete strobe, and signals a slave-side termination when a burst runs off the top of its storage. A small register array inside the block holds the data.

There are three kinds of transfer. A single transfer has the burst flag low; its byte enables select the byte lanes of a write. A fixed-length burst has the burst flag high and a non-zero beat count on the byte-enable lines; because the slave knows the length, it can announce completion one beat early, so the next transfer can follow without a dead cycle. A variable-length burst has the burst flag high and zero on the byte enables, and it runs until the master drops its burst line. The master may also drop the burst line to cut a fixed-length burst short.

The controller is a four-state machine. IDLE accepts an address. READ_WAIT fills the read latency. READ_BEAT and WRITE_BEAT each produce one data acknowledge per cycle. The transitions are: IDLE to READ_WAIT on an accepted read. IDLE to WRITE_BEAT on an accepted write whose first beat is not its last. IDLE stays in IDLE on a write whose first beat is its last. READ_WAIT goes to READ_BEAT unconditionally. Each beat state loops on itself until the final beat, which returns it to IDLE.

Top module: `bst_slave_ctrl`

## Requirements
- R1: After reset the block is in IDLE with every output low, and every storage word reads back as zero.
- R2: `addr_ack` is high in exactly the cycles where `req_valid` is high and no data phase is pending. A request held high during an earlier transfer's data phase is acknowledged only in the cycle after that transfer's final beat.
- R3: A write's first `wr_dack` is in the same cycle as its `addr_ack`, and later beats follow on consecutive cycles at consecutive word addresses. Each beat stores `wr_data`. A single write updates only the byte lanes whose `req_be` bit i is set, where lane i is bits 8i+7..8i. Burst writes update all lanes.
- R4: A read's first `rd_dack` comes exactly two cycles after its `addr_ack`, with no `rd_dack` in the cycle between. Later beats follow on consecutive cycles. `rd_data` carries the addressed word while `rd_dack` is high and is zero otherwise.
- R5: A transfer with `req_burst` low has exactly one data beat, and `xfer_done` is high together with that beat.
- R6: A fixed burst with `req_burst` high and `req_be` = N (N non-zero) makes N beats from `req_addr` upward. `xfer_done` is high on beat N-1 when N is at least 2, and on the only beat when N is 1. It is high once per transfer.
- R7: For a variable burst (`req_be` zero), the beat during which `req_burst` is sampled low is followed by exactly one more beat. That beat carries `xfer_done`.
- R8: If `req_burst` is low during a beat of a fixed burst before its planned last beat, the next beat is the final one. It carries `xfer_done` unless completion was already signalled.
- R9: A burst never passes the top word (index 2^AW-1). A burst that reaches the top word before its own end stops there, and `slv_term` is high with that beat. A shortened fixed burst signals `xfer_done` by the R6 rule applied to its shortened length. `slv_term` is never high outside a beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address phase valid |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_burst | input | 1 | Burst flag at the address phase; burst-continue line during beats |
| req_be | input | DW/8 | Byte lanes of a single write; beat count of a fixed burst |
| req_addr | input | AW | Word address of the first beat |
| wr_data | input | DW | Write data for the current beat |
| addr_ack | output | 1 | Address acknowledge |
| wr_dack | output | 1 | Write data acknowledge |
| rd_dack | output | 1 | Read data acknowledge |
| rd_data | output | DW | Read data, zero when no read beat |
| xfer_done | output | 1 | Transfer complete (early for fixed bursts) |
| slv_term | output | 1 | Slave-side burst termination at top of storage |

## Verification
The bench uses DW = 32 and AW = 4, so storage is 16 words and the byte-enable field can request fixed bursts of up to 15 beats. That depth is small enough for bursts to reach the top word: fixed lengths longer than the remaining room, and variable bursts left running, both meet the slave-side stop within a few beats. The stimulus covers single-beat and one-word-room fixed bursts, fixed bursts cut short by the master, and a request raised during another transfer's data phase, so that the deferred acknowledge can be observed.

// File: rtl/bst_pkg.sv
package bst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RWAIT = 2'd1,
        ST_RBEAT = 2'd2,
        ST_WBEAT = 2'd3
    } bst_state_e;

endpackage

// File: rtl/bst_len_decode.sv
module bst_len_decode #(
    parameter int AW   = 4,
    parameter int BE_W = 4,
    parameter int LW   = 5
) (
    input  logic            burst,
    input  logic [BE_W-1:0] be,
    input  logic [AW-1:0]   addr,
    output logic [LW-1:0]   cnt,
    output logic            fixed,
    output logic            cut
);
    localparam logic [LW-1:0] DEPTH_L = LW'(1) << AW;

    logic [LW-1:0] room;
    logic [LW-1:0] want;

    always_comb begin
        room  = DEPTH_L - LW'(addr);
        want  = LW'(be);
        fixed = burst && (be != '0);
        if (!burst) begin
            cnt = LW'(1);
            cut = 1'b0;
        end else if (fixed) begin
            cut = (want > room);
            cnt = cut ? room : want;
        end else begin
            cnt = room;
            cut = 1'b1;
        end
    end

endmodule

// File: rtl/bst_mem.sv
module bst_mem #(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [DW/8-1:0] wmask,
    input  logic [DW-1:0]   wdata,
    input  logic [AW-1:0]   raddr,
    output logic [DW-1:0]   rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int NLANE = DW / 8;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (we) begin
            for (int j = 0; j < NLANE; j++) begin
                if (wmask[j]) begin
                    words[waddr][8*j +: 8] <= wdata[8*j +: 8];
                end
            end
        end
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/bst_slave_ctrl.sv
module bst_slave_ctrl #(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_rnw,
    input  logic            req_burst,
    input  logic [DW/8-1:0] req_be,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   wr_data,
    output logic            addr_ack,
    output logic            wr_dack,
    output logic            rd_dack,
    output logic [DW-1:0]   rd_data,
    output logic            xfer_done,
    output logic            slv_term
);
    import bst_pkg::*;

    localparam int BE_W = DW / 8;
    localparam int LW   = (BE_W > AW + 1) ? BE_W : AW + 1;

    bst_state_e    state_q, state_d;
    logic [AW-1:0] ptr_q, ptr_d;
    logic [LW-1:0] left_q, left_d;
    logic          fixed_q, fixed_d;
    logic          cut_q, cut_d;
    logic          mstop_q, mstop_d;
    logic          done_q, done_d;

    logic [LW-1:0] dec_cnt;
    logic          dec_fixed;
    logic          dec_cut;

    logic [AW-1:0] b_ptr;
    logic [LW-1:0] b_left;
    logic          b_fixed, b_cut, b_mstop, b_done;
    logic          beat, last;

    logic            mem_we;
    logic [BE_W-1:0] mem_mask;
    logic [DW-1:0]   mem_rd;

    bst_len_decode #(.AW(AW), .BE_W(BE_W), .LW(LW)) u_dec (
        .burst (req_burst),
        .be    (req_be),
        .addr  (req_addr),
        .cnt   (dec_cnt),
        .fixed (dec_fixed),
        .cut   (dec_cut)
    );

    bst_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (b_ptr),
        .wmask (mem_mask),
        .wdata (wr_data),
        .raddr (ptr_q),
        .rdata (mem_rd)
    );

    // State register and transfer context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            left_q  <= '0;
            fixed_q <= 1'b0;
            cut_q   <= 1'b0;
            mstop_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            left_q  <= left_d;
            fixed_q <= fixed_d;
            cut_q   <= cut_d;
            mstop_q <= mstop_d;
            done_q  <= done_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        ptr_d     = ptr_q;
        left_d    = left_q;
        fixed_d   = fixed_q;
        cut_d     = cut_q;
        mstop_d   = mstop_q;
        done_d    = done_q;
        b_ptr     = ptr_q;
        b_left    = left_q;
        b_fixed   = fixed_q;
        b_cut     = cut_q;
        b_mstop   = mstop_q;
        b_done    = done_q;
        beat      = 1'b0;
        addr_ack  = 1'b0;
        wr_dack   = 1'b0;
        rd_dack   = 1'b0;
        xfer_done = 1'b0;
        slv_term  = 1'b0;
        mem_we    = 1'b0;
        mem_mask  = '1;

        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    addr_ack = 1'b1;
                    b_ptr    = req_addr;
                    b_left   = dec_cnt;
                    b_fixed  = dec_fixed;
                    b_cut    = dec_cut;
                    b_mstop  = 1'b0;
                    b_done   = 1'b0;
                    ptr_d    = req_addr;
                    left_d   = dec_cnt;
                    fixed_d  = dec_fixed;
                    cut_d    = dec_cut;
                    mstop_d  = 1'b0;
                    done_d   = 1'b0;
                    if (req_rnw) begin
                        state_d = ST_RWAIT;
                    end else begin
                        beat    = 1'b1;
                        wr_dack = 1'b1;
                        mem_we  = 1'b1;
                        if (!req_burst) begin
                            mem_mask = req_be;
                        end
                    end
                end
            end
            ST_RWAIT: begin
                state_d = ST_RBEAT;
            end
            ST_RBEAT: begin
                beat    = 1'b1;
                rd_dack = 1'b1;
            end
            ST_WBEAT: begin
                beat    = 1'b1;
                wr_dack = 1'b1;
                mem_we  = 1'b1;
            end
        endcase

        last = (b_left == LW'(1)) || b_mstop;

        if (beat) begin
            xfer_done = !b_done && (last || (b_fixed && (b_left == LW'(2))));
            slv_term  = (b_left == LW'(1)) && b_cut && !b_mstop;
            ptr_d     = b_ptr + AW'(1);
            left_d    = b_left - LW'(1);
            mstop_d   = !req_burst;
            done_d    = b_done || xfer_done;
            if (last) begin
                state_d = ST_IDLE;
            end else if (wr_dack) begin
                state_d = ST_WBEAT;
            end else begin
                state_d = ST_RBEAT;
            end
        end

        rd_data = rd_dack ? mem_rd : '0;
    end

endmodule

// File: rtl/bst_slave_ctrl_chk.sv
module bst_slave_ctrl_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_rnw,
    input logic          addr_ack,
    input logic          wr_dack,
    input logic          rd_dack,
    input logic [DW-1:0] rd_data,
    input logic          xfer_done,
    input logic          slv_term
);

    a_r3_wr_dack_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ack && !req_rnw) |-> wr_dack);

    a_r4_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ack && req_rnw) |=> !rd_dack ##1 rd_dack);

    a_r4_rd_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_dack |-> (rd_data == '0));

    a_r2_no_ack_mid_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dack || (wr_dack && !addr_ack)) |-> !addr_ack);

    a_r2_ack_not_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ack && req_rnw) |=> !addr_ack);

    a_r6_done_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (rd_dack || wr_dack));

    a_r9_term_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        slv_term |-> ((rd_dack || wr_dack) && $onehot0({rd_dack, wr_dack})));

    a_r3_one_dack_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_dack, wr_dack}));

endmodule

bind bst_slave_ctrl bst_slave_ctrl_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_rnw   (req_rnw),
    .addr_ack  (addr_ack),
    .wr_dack   (wr_dack),
    .rd_dack   (rd_dack),
    .rd_data   (rd_data),
    .xfer_done (xfer_done),
    .slv_term  (slv_term)
);

// File: tb/bst_slave_ctrl_bench.sv
`timescale 1ns/1ps
module bst_slave_ctrl_bench;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int NW = 16;
    localparam int NT = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_rnw = 1'b0;
    logic          req_burst = 1'b0;
    logic [3:0]    req_be = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          addr_ack, wr_dack, rd_dack, xfer_done, slv_term;
    logic [DW-1:0] rd_data;

    always #2.5 clk = ~clk;

    bst_slave_ctrl #(.DW(DW), .AW(AW)) u_bst_slave_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rnw(req_rnw),
        .req_burst(req_burst), .req_be(req_be), .req_addr(req_addr),
        .wr_data(wr_data), .addr_ack(addr_ack), .wr_dack(wr_dack),
        .rd_dack(rd_dack), .rd_data(rd_data), .xfer_done(xfer_done),
        .slv_term(slv_term)
    );

    int checks = 0;
    int errors = 0;

    // Transfer list
    logic       d_rnw   [NT];
    logic       d_burst [NT];
    logic [3:0] d_be    [NT];
    logic [3:0] d_addr  [NT];
    int         d_drop  [NT];
    int         d_gap   [NT];
    string      d_tag   [NT];

    task automatic put(input int i, input logic rnw, input logic bu, input logic [3:0] be,
                       input logic [3:0] ad, input int drop, input int gap, input string tag);
        d_rnw[i] = rnw; d_burst[i] = bu; d_be[i] = be; d_addr[i] = ad;
        d_drop[i] = drop; d_gap[i] = gap; d_tag[i] = tag;
    endtask

    initial begin
        put(0,  1, 0, 4'h0, 4'd3,  99, 22, "R1");
        put(1,  0, 0, 4'h5, 4'd2,  99, 22, "R3");
        put(2,  1, 0, 4'hF, 4'd2,  99, 22, "R5");
        put(3,  0, 1, 4'd4, 4'd4,  99, 22, "R6");
        put(4,  1, 1, 4'd4, 4'd4,  99, 22, "R6");
        put(5,  0, 1, 4'd1, 4'd9,  99, 22, "R6");
        put(6,  1, 1, 4'd2, 4'd4,  99, 22, "R6");
        put(7,  0, 1, 4'd0, 4'd0,   3, 22, "R7");
        put(8,  1, 1, 4'd0, 4'd0,   0, 22, "R7");
        put(9,  0, 1, 4'd8, 4'd1,   2, 22, "R8");
        put(10, 1, 1, 4'd6, 4'd0,   1, 22, "R8");
        put(11, 0, 1, 4'd9, 4'd12, 99, 22, "R9");
        put(12, 0, 1, 4'd0, 4'd13, 99, 22, "R9");
        put(13, 1, 1, 4'd0, 4'd10, 99, 22, "R9");
        put(14, 1, 1, 4'd15, 4'd0, 99, 22, "R6");
        put(15, 0, 1, 4'd3, 4'd5,  99, 22, "R2");
        put(16, 1, 1, 4'd3, 4'd5,  99,  0, "R2");
        put(17, 1, 1, 4'd1, 4'd15, 99, 22, "R6");
        put(18, 1, 1, 4'd2, 4'd15, 99, 22, "R9");
    end

    // Observations used by the driver
    logic  ack_seen = 1'b0;
    int    since_ack = 100;
    int    dcnt = 0;
    int    cur_drop = 99;
    string cur_tag = "R1";
    bit    finished = 1'b0;

    // Driver: inputs change 1 ns after the rising edge
    initial begin
        int ti;
        ti = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            wr_data = $urandom;
            if (req_valid && ack_seen) req_valid = 1'b0;
            if (!req_valid && ti < NT && since_ack >= d_gap[ti]) begin
                req_valid = 1'b1;
                req_rnw   = d_rnw[ti];
                req_burst = d_burst[ti];
                req_be    = d_be[ti];
                req_addr  = d_addr[ti];
                cur_drop  = d_drop[ti];
                cur_tag   = d_tag[ti];
                ti++;
            end
            if (!req_valid) req_burst = (dcnt < cur_drop);
            if (ti == NT && !req_valid && since_ack >= 25) finished = 1'b1;
        end
    end

    // Behavioural reference
    logic [DW-1:0] m_mem [NW];
    bit  m_busy = 0, m_rd = 0, m_fixed = 0, m_capped = 0, m_done = 0, m_stop = 0;
    int  m_wait = 0, m_ptr = 0, m_cap = 0, m_beat = 0;
    logic          e_ack, e_wd, e_rd, e_done, e_term;
    logic [DW-1:0] e_data;

    initial for (int i = 0; i < NW; i++) m_mem[i] = '0;

    task automatic chk(input string tag, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic do_beat(input logic [3:0] mask);
        bit fin;
        fin    = (m_beat + 1 >= m_cap) || m_stop;
        e_done = !m_done && (fin || (m_fixed && (m_beat + 2 == m_cap) && !m_stop));
        e_term = fin && m_capped && !m_stop && (m_beat + 1 == m_cap);
        if (m_rd) begin
            e_rd   = 1'b1;
            e_data = m_mem[m_ptr];
        end else begin
            e_wd = 1'b1;
            for (int k = 0; k < 4; k++)
                if (mask[k]) m_mem[m_ptr][8*k +: 8] = wr_data[8*k +: 8];
        end
        m_done = m_done || e_done;
        m_stop = !req_burst;
        m_beat++;
        m_ptr++;
        if (fin) m_busy = 0;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            // R1: outputs quiet under reset with no request
            chk("R1", "addr_ack", {31'd0, addr_ack}, '0);
            chk("R1", "dacks", {30'd0, wr_dack, rd_dack}, '0);
            chk("R1", "done/term", {30'd0, xfer_done, slv_term}, '0);
        end else begin
            e_ack = 0; e_wd = 0; e_rd = 0; e_done = 0; e_term = 0; e_data = '0;
            if (!m_busy) begin
                if (req_valid) begin
                    int lim;
                    e_ack    = 1'b1;
                    m_rd     = req_rnw;
                    m_ptr    = int'(req_addr);
                    lim      = NW - m_ptr;
                    m_fixed  = req_burst && (req_be != 0);
                    if (!req_burst) m_cap = 1;
                    else if (req_be != 0) m_cap = (int'(req_be) < lim) ? int'(req_be) : lim;
                    else m_cap = lim;
                    m_capped = req_burst && ((req_be == 0) || (int'(req_be) > lim));
                    m_done = 0; m_stop = 0; m_beat = 0; m_busy = 1;
                    if (m_rd) m_wait = 1;
                    else do_beat(req_burst ? 4'hF : req_be);
                end
            end else if (m_rd && m_wait > 0) begin
                m_wait--;
            end else begin
                do_beat(4'hF);
            end
            chk("R2", "addr_ack", {31'd0, addr_ack}, {31'd0, e_ack});
            chk("R3", "wr_dack", {31'd0, wr_dack}, {31'd0, e_wd});
            chk("R4", "rd_dack", {31'd0, rd_dack}, {31'd0, e_rd});
            chk(cur_tag == "R1" ? "R1" : "R4", "rd_data", rd_data, e_data);
            chk(cur_tag, "xfer_done", {31'd0, xfer_done}, {31'd0, e_done});
            chk("R9", "slv_term", {31'd0, slv_term}, {31'd0, e_term});

            // driver bookkeeping from the observed ports
            ack_seen = addr_ack;
            if (addr_ack) begin
                since_ack = 0;
                dcnt = wr_dack ? 1 : 0;
            end else begin
                since_ack++;
                dcnt += (wr_dack || rd_dack) ? 1 : 0;
            end
        end
    end

    // Watchdog and summary
    initial begin
        int cyc;
        cyc = 0;
        while (!finished && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule